// File: doc/BRIEF.md
# Indirect-Addressed Parallel Host Register Port

This block is the slave end of an 8-bit asynchronous parallel host bus. The bus has an address/data select line, an active-low select, active-low write and read strobes, and a byte-wide data path. The host never presents a register address on wires. It first sends a 19-bit address as three command bytes (select line low). It then moves 16-bit register values in data mode (select line high), one byte per strobe, low byte first. After each completed 16-bit transfer the internal address pointer steps to the next register. Several consecutive registers can therefore be streamed after a single address phase.

The bus inputs are brought into a fast system clock through a two-flop synchronizer. The strobe edges are then detected in that clock. A write byte is taken when the write access ends, which is when the first of the select or the write strobe returns high. The block holds a small register file inside a 32-byte window at a parameterised base address:

- a power-mode register;
- a write-only soft-reset register;
- three clock-configuration registers, which are write-locked outside the deepest power mode;
- a set of general scratch registers.

The read data path is split into a data output and an output enable for the pad.

Top module: `pbus_reg_port`

## Requirements
- R1: After reset, and with the bus idle, `bus_doe` is 0. Registers read their defaults: mode (offset 0x00) = 0x0000, clock multiplier (0x06) = 0x2C0B, clock divider (0x08) = 0x0003, and every scratch register (0x10, 0x12, 0x14, 0x16) = 0x0000.
- R2: Three successive write strobes with `bus_a0`=0 load address bits [7:0], then [15:8], then [18:16]. Only bits [2:0] of the third byte are used. Any data-mode access returns the command byte count to the first byte, and any command byte returns the data byte phase to the low byte.
- R3: A data write (`bus_a0`=1) stores the low byte first. The register changes only when the following high byte arrives, and then takes {high, low}. A data read returns bits [7:0] on the first strobe and bits [15:8] on the second.
- R4: After the high byte of a read or a write, the address pointer advances by 2, so the next data access reaches the next register.
- R5: A write byte is captured when the write access ends. This is the first rising edge of either `bus_cs_n` or `bus_wr_n`, whichever comes first.
- R6: A strobe with `bus_a0`=0 and `bus_rd_n` low is inhibited. It drives no data (`bus_doe`=0) and changes neither the address pointer nor the byte phase.
- R7: `bus_doe` is 1 only while `bus_cs_n`=0, `bus_rd_n`=0 and `bus_a0`=1. It is 0 during writes and while idle.
- R8: The mode register (0x00) keeps bits [1:0] and reads 0 in bits [15:2]. Mode 00 is the deepest power-save mode, 01 a light save mode and 1x normal running. The clock registers at 0x04, 0x06 and 0x08 accept writes only while the mode is 00; otherwise the write is ignored.
- R9: The clock control register (0x04) holds an enable bit [0] and a bypass bit [1]. Its bit [15] is a read-only lock flag that reads as the enable bit, and host writes to bit [15] are ignored.
- R10: Writing the soft-reset register (0x02) with bit [8]=1 returns every register to its R1 default. Writing it with bit [8]=0 has no effect. The register always reads 0x0000.
- R11: Addresses outside the window, and unassigned offsets inside it (for example 0x0A), read 0x0000 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus strobes |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Bus select, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_a0 | input | 1 | 0 = command/address byte, 1 = data byte |
| bus_din | input | 8 | Byte from the host on writes |
| bus_dout | output | 8 | Byte toward the host on reads |
| bus_doe | output | 1 | Pad output enable for `bus_dout` |

## Verification
The checks assume that the host keeps `bus_a0` and `bus_din` steady from before its strobe falls until several system clocks after the strobe rises. They also assume that write and read are never low together, and that every strobe level lasts longer than the synchronizer delay. The bench honours this by moving every bus signal on falling clock edges and holding each level for at least two clocks. It holds the data past the end of the access and leaves eight idle clocks between accesses. Under those conditions the output-enable rules, the high-byte commit and the step of two after it are asserted cycle by cycle. The register contents are compared against a shadow model kept in the bench.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    localparam int ADDR_W    = 19;
    localparam int DATA_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int CMD_BYTES = (ADDR_W + BYTE_W - 1) / BYTE_W;
    localparam int CMD_CW    = $clog2(CMD_BYTES);
    localparam int WIN_LSB   = 5;

    localparam logic [WIN_LSB-1:0] OFS_MODE = 5'h00;
    localparam logic [WIN_LSB-1:0] OFS_SRST = 5'h02;
    localparam logic [WIN_LSB-1:0] OFS_CTL  = 5'h04;
    localparam logic [WIN_LSB-1:0] OFS_MUL  = 5'h06;
    localparam logic [WIN_LSB-1:0] OFS_DIV  = 5'h08;

    localparam logic [1:0] MODE_DEEP = 2'b00;
    localparam int SRST_BIT = 8;

    typedef enum logic [2:0] {
        REG_NONE, REG_MODE, REG_SRST, REG_CTL, REG_MUL, REG_DIV, REG_SCR
    } reg_id_e;

    typedef struct packed {
        logic              cs_n;
        logic              wr_n;
        logic              rd_n;
        logic              a0;
        logic [BYTE_W-1:0] d;
    } bus_smp_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    localparam bus_smp_t BUS_IDLE = '{cs_n: 1'b1, wr_n: 1'b1, rd_n: 1'b1,
                                      a0: 1'b0, d: '0};

    function automatic reg_id_e decode(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] base,
                                       input int unsigned       nscr);
        logic [WIN_LSB-1:0] ofs;
        ofs = {a[WIN_LSB-1:1], 1'b0};
        if (a[ADDR_W-1:WIN_LSB] != base[ADDR_W-1:WIN_LSB]) return REG_NONE;
        if (ofs[WIN_LSB-1]) return (int'(a[WIN_LSB-2:1]) < int'(nscr)) ? REG_SCR : REG_NONE;
        case (ofs)
            OFS_MODE: return REG_MODE;
            OFS_SRST: return REG_SRST;
            OFS_CTL:  return REG_CTL;
            OFS_MUL:  return REG_MUL;
            OFS_DIV:  return REG_DIV;
            default:  return REG_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)         stg[i] <= RST_VAL;
            else if (i == 0) stg[i] <= d;
            else             stg[i] <= stg[(i == 0) ? 0 : i - 1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
    import pbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_smp_t          now,
    output logic              wr_stb,
    output wr_req_t           wr_req,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cur_hi
);
    localparam int PAD_W = CMD_BYTES * BYTE_W;

    bus_smp_t            prev;
    logic [PAD_W-1:0]    addr_pad;
    logic [CMD_CW-1:0]   cmd_cnt;
    logic [BYTE_W-1:0]   lo_q;
    logic                wr_act_now, wr_act_prev, rd_act_now, rd_act_prev;
    logic                wr_end, rd_end;
    logic [ADDR_W-1:0]   addr_next;

    assign cur_addr    = addr_pad[ADDR_W-1:0];
    assign addr_next   = cur_addr + ADDR_W'(2);

    // a write access is open while select and write are low with read high
    assign wr_act_now  = !now.cs_n  && !now.wr_n  && now.rd_n;
    assign wr_act_prev = !prev.cs_n && !prev.wr_n && prev.rd_n;
    // only data reads count; select-low reads are inhibited
    assign rd_act_now  = !now.cs_n  && !now.rd_n  && now.wr_n  && now.a0;
    assign rd_act_prev = !prev.cs_n && !prev.rd_n && prev.wr_n && prev.a0;

    assign wr_end = wr_act_prev && !wr_act_now;
    assign rd_end = rd_act_prev && !rd_act_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev     <= BUS_IDLE;
            addr_pad <= '0;
            cmd_cnt  <= '0;
            lo_q     <= '0;
            cur_hi   <= 1'b0;
            wr_stb   <= 1'b0;
            wr_req   <= '0;
        end else begin
            prev   <= now;
            wr_stb <= 1'b0;
            if (wr_end) begin
                if (!prev.a0) begin
                    addr_pad[{cmd_cnt, 3'b000} +: BYTE_W] <= prev.d;
                    cmd_cnt <= (int'(cmd_cnt) == CMD_BYTES - 1) ? '0 : cmd_cnt + 1'b1;
                    cur_hi  <= 1'b0;
                end else begin
                    cmd_cnt <= '0;
                    if (!cur_hi) begin
                        lo_q   <= prev.d;
                        cur_hi <= 1'b1;
                    end else begin
                        wr_stb      <= 1'b1;
                        wr_req.addr <= cur_addr;
                        wr_req.data <= {prev.d, lo_q};
                        addr_pad    <= PAD_W'(addr_next);
                        cur_hi      <= 1'b0;
                    end
                end
            end else if (rd_end) begin
                cmd_cnt <= '0;
                if (!cur_hi) begin
                    cur_hi <= 1'b1;
                end else begin
                    addr_pad <= PAD_W'(addr_next);
                    cur_hi   <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/pbus_regfile.sv
module pbus_regfile
    import pbus_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE     = 19'h4_0000,
    parameter int                NUM_SCR  = 4,
    parameter int                DIV_W    = 4,
    parameter logic [15:0]       MUL_DEF  = 16'h2C0B,
    parameter logic [DIV_W-1:0]  DIV_DEF  = 4'h3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  wr_req_t           wr_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int SCR_IW = (NUM_SCR > 1) ? $clog2(NUM_SCR) : 1;

    logic [1:0]        mode_q;
    logic [1:0]        ctl_q;
    logic [DATA_W-1:0] mul_q;
    logic [DIV_W-1:0]  div_q;
    logic [NUM_SCR-1:0][DATA_W-1:0] scr_q;

    reg_id_e           wid, rid;
    logic              unlocked, soft_rst, clr;
    logic [SCR_IW-1:0] widx, ridx;

    assign wid      = decode(wr_req.addr, BASE, NUM_SCR);
    assign rid      = decode(rd_addr, BASE, NUM_SCR);
    assign widx     = wr_req.addr[SCR_IW:1];
    assign ridx     = rd_addr[SCR_IW:1];
    assign unlocked = (mode_q == MODE_DEEP);
    assign soft_rst = wr_stb && (wid == REG_SRST) && wr_req.data[SRST_BIT];
    assign clr      = rst || soft_rst;

    always_ff @(posedge clk) begin
        if (clr) begin
            mode_q <= MODE_DEEP;
            ctl_q  <= '0;
            mul_q  <= MUL_DEF;
            div_q  <= DIV_DEF;
        end else if (wr_stb) begin
            case (wid)
                REG_MODE: mode_q <= wr_req.data[1:0];
                REG_CTL:  if (unlocked) ctl_q <= wr_req.data[1:0];
                REG_MUL:  if (unlocked) mul_q <= wr_req.data;
                REG_DIV:  if (unlocked) div_q <= wr_req.data[DIV_W-1:0];
                default: ;
            endcase
        end
    end

    for (genvar s = 0; s < NUM_SCR; s++) begin : g_scr
        always_ff @(posedge clk) begin
            if (clr)
                scr_q[s] <= '0;
            else if (wr_stb && wid == REG_SCR && int'(widx) == s)
                scr_q[s] <= wr_req.data;
        end
    end

    always_comb begin
        case (rid)
            REG_MODE: rd_data = {14'b0, mode_q};
            REG_CTL:  rd_data = {ctl_q[0], 13'b0, ctl_q};
            REG_MUL:  rd_data = mul_q;
            REG_DIV:  rd_data = DATA_W'(div_q);
            REG_SCR:  rd_data = scr_q[ridx];
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/pbus_reg_port.sv
module pbus_reg_port
    import pbus_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE        = 19'h4_0000,
    parameter int                NUM_SCR     = 4,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_cs_n,
    input  logic              bus_wr_n,
    input  logic              bus_rd_n,
    input  logic              bus_a0,
    input  logic [BYTE_W-1:0] bus_din,
    output logic [BYTE_W-1:0] bus_dout,
    output logic              bus_doe
);
    bus_smp_t          raw, syn;
    logic              wr_stb;
    wr_req_t           wr_req;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_hi;
    logic [DATA_W-1:0] rd_data;

    assign raw = '{cs_n: bus_cs_n, wr_n: bus_wr_n, rd_n: bus_rd_n,
                   a0: bus_a0, d: bus_din};

    pbus_sync #(
        .WIDTH   ($bits(bus_smp_t)),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (BUS_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (syn)
    );

    pbus_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .now      (syn),
        .wr_stb   (wr_stb),
        .wr_req   (wr_req),
        .cur_addr (cur_addr),
        .cur_hi   (cur_hi)
    );

    pbus_regfile #(
        .BASE    (BASE),
        .NUM_SCR (NUM_SCR)
    ) u_rf (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .wr_req  (wr_req),
        .rd_addr (cur_addr),
        .rd_data (rd_data)
    );

    // pad enable follows the raw pins so the bus is released at once
    assign bus_doe  = !bus_cs_n && !bus_rd_n && bus_a0;
    assign bus_dout = cur_hi ? rd_data[DATA_W-1:BYTE_W] : rd_data[BYTE_W-1:0];
endmodule

// File: rtl/pbus_reg_port_chk.sv
module pbus_reg_port_chk
    import pbus_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              rd_n,
    input logic              a0,
    input logic              doe,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              cur_hi
);
    assert_doe_needs_read_R7: assert property (@(posedge clk) disable iff (rst)
        doe |-> (!cs_n && !rd_n));

    assert_doe_needs_data_R7: assert property (@(posedge clk) disable iff (rst)
        doe |-> a0);

    assert_inhibit_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !rd_n && !a0) |-> !doe);

    assert_commit_after_low_R3: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> $past(cur_hi));

    assert_step_two_R4: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> (cur_addr == ADDR_W'(wr_addr + ADDR_W'(2))));

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!cur_hi && !wr_stb && cur_addr == '0));
endmodule

bind pbus_reg_port pbus_reg_port_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (bus_cs_n),
    .rd_n     (bus_rd_n),
    .a0       (bus_a0),
    .doe      (bus_doe),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_req.addr),
    .cur_addr (cur_addr),
    .cur_hi   (cur_hi)
);

// File: tb/test_pbus_reg_port.sv
`timescale 1ns/1ps
module test_pbus_reg_port;
    localparam logic [18:0] BASE   = 19'h4_0000;
    localparam logic [18:0] A_MODE = BASE + 19'h00;
    localparam logic [18:0] A_SRST = BASE + 19'h02;
    localparam logic [18:0] A_CTL  = BASE + 19'h04;
    localparam logic [18:0] A_MUL  = BASE + 19'h06;
    localparam logic [18:0] A_DIV  = BASE + 19'h08;
    localparam logic [18:0] A_HOLE = BASE + 19'h0A;
    localparam logic [18:0] A_SCR  = BASE + 19'h10;
    localparam int NSCR = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_cs_n = 1'b1, bus_wr_n = 1'b1, bus_rd_n = 1'b1, bus_a0 = 1'b0;
    logic [7:0] bus_din = '0;
    logic [7:0] bus_dout;
    logic       bus_doe;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [15:0] shadow [NSCR];

    always #2 clk = ~clk;

    pbus_reg_port #(.BASE(BASE), .NUM_SCR(NSCR)) i_pbus_reg_port (
        .clk      (clk),
        .rst      (rst),
        .bus_cs_n (bus_cs_n),
        .bus_wr_n (bus_wr_n),
        .bus_rd_n (bus_rd_n),
        .bus_a0   (bus_a0),
        .bus_din  (bus_din),
        .bus_dout (bus_dout),
        .bus_doe  (bus_doe)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic strobe_wr(input logic a0, input logic [7:0] d, input bit cs_first);
        @(negedge clk);
        bus_a0 = a0; bus_din = d; bus_cs_n = 1'b0;
        repeat (2) @(negedge clk);
        bus_wr_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 doe low during write", 16'(bus_doe), 16'h0);
        @(negedge clk);
        if (cs_first) bus_cs_n = 1'b1; else bus_wr_n = 1'b1;
        repeat (3) @(negedge clk);
        bus_wr_n = 1'b1; bus_cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic strobe_rd(output logic [7:0] d);
        @(negedge clk);
        bus_a0 = 1'b1; bus_cs_n = 1'b0;
        repeat (2) @(negedge clk);
        bus_rd_n = 1'b0;
        repeat (6) @(negedge clk);
        check("R7 doe high during data read", 16'(bus_doe), 16'h1);
        d = bus_dout;
        bus_rd_n = 1'b1;
        repeat (2) @(negedge clk);
        bus_cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic strobe_inhibit();
        @(negedge clk);
        bus_a0 = 1'b0; bus_cs_n = 1'b0;
        repeat (2) @(negedge clk);
        bus_rd_n = 1'b0;
        repeat (6) @(negedge clk);
        check("R6 doe low on inhibited read", 16'(bus_doe), 16'h0);
        bus_rd_n = 1'b1;
        repeat (2) @(negedge clk);
        bus_cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    // R2: third command byte carries junk in bits [7:3]
    task automatic set_addr(input logic [18:0] a);
        strobe_wr(1'b0, a[7:0], 1'b0);
        strobe_wr(1'b0, a[15:8], 1'b0);
        strobe_wr(1'b0, {5'b10101, a[18:16]}, 1'b0);
    endtask

    task automatic wr16(input logic [15:0] v);
        strobe_wr(1'b1, v[7:0], 1'b0);
        strobe_wr(1'b1, v[15:8], 1'b0);
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] lo, hi;
        strobe_rd(lo);
        strobe_rd(hi);
        v = {hi, lo};
    endtask

    task automatic reg_wr(input logic [18:0] a, input logic [15:0] v);
        set_addr(a); wr16(v);
    endtask

    task automatic reg_chk(input string req, input logic [18:0] a, input logic [15:0] exp);
        logic [15:0] v;
        set_addr(a); rd16(v);
        check(req, v, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  b0, b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1 reset state
        check("R1 doe idle", 16'(bus_doe), 16'h0);
        reg_chk("R1 mode default", A_MODE, 16'h0000);
        reg_chk("R1 mul default", A_MUL, 16'h2C0B);
        reg_chk("R1 div default", A_DIV, 16'h0003);
        for (int i = 0; i < NSCR; i++) begin
            reg_chk("R1 scratch default", A_SCR + 19'(2 * i), 16'h0000);
            shadow[i] = 16'h0;
        end

        // R3 sweep over scratch registers and patterns
        for (int i = 0; i < NSCR; i++) begin
            for (int k = 0; k < 6; k++) begin
                v = 16'((i * 16'h1357 + k * 16'h2468) ^ 16'hA5A5);
                reg_wr(A_SCR + 19'(2 * i), v);
                shadow[i] = v;
                reg_chk("R3 scratch write/read", A_SCR + 19'(2 * i), v);
            end
        end

        // R3 low byte alone does not commit
        set_addr(A_SCR + 19'h2);
        strobe_wr(1'b1, 8'h77, 1'b0);
        reg_chk("R3 no commit on low byte", A_SCR + 19'h2, shadow[1]);

        // R3 byte order on read
        set_addr(A_SCR);
        strobe_rd(b0);
        check("R3 low byte first", 16'(b0), 16'(shadow[0][7:0]));
        strobe_rd(b1);
        check("R3 high byte second", 16'(b1), 16'(shadow[0][15:8]));

        // R4 streaming write then streaming read
        set_addr(A_SCR);
        for (int i = 0; i < NSCR; i++) begin
            v = 16'(16'hC000 + i * 16'h0111);
            wr16(v);
            shadow[i] = v;
        end
        // R11 pointer now past the scratch block
        wr16(16'hDEAD);
        set_addr(A_SCR);
        for (int i = 0; i < NSCR; i++) begin
            rd16(v);
            check("R4 streamed read", v, shadow[i]);
        end
        rd16(v);
        check("R11 read past scratch block", v, 16'h0000);

        // R5 capture when select rises before write
        set_addr(A_SCR + 19'h4);
        strobe_wr(1'b1, 8'h3C, 1'b1);
        strobe_wr(1'b1, 8'h96, 1'b1);
        shadow[2] = 16'h963C;
        reg_chk("R5 select-first end of write", A_SCR + 19'h4, 16'h963C);

        // R6 inhibited read changes nothing
        set_addr(A_SCR + 19'h6);
        strobe_inhibit();
        rd16(v);
        check("R6 inhibit before read", v, shadow[3]);
        set_addr(A_SCR);
        strobe_rd(b0);
        strobe_inhibit();
        strobe_rd(b1);
        check("R6 inhibit between bytes", {b1, b0}, shadow[0]);

        // R2 stray command byte cleared by a data access
        strobe_wr(1'b0, 8'h55, 1'b0);
        strobe_rd(b0);
        reg_chk("R2 command count restart", A_SCR + 19'h2, shadow[1]);
        reg_chk("R2 top address byte bits [7:3] ignored", A_MUL, 16'h2C0B);

        // R9 lock flag mirrors enable, bit 15 not writable
        reg_wr(A_CTL, 16'h0001);
        reg_chk("R9 lock mirrors enable", A_CTL, 16'h8001);
        reg_wr(A_CTL, 16'h8002);
        reg_chk("R9 bit 15 write ignored", A_CTL, 16'h0002);

        // R8 mode width and write lock
        reg_wr(A_MODE, 16'hFFFF);
        reg_chk("R8 mode keeps two bits", A_MODE, 16'h0003);
        reg_wr(A_MUL, 16'h1234);
        reg_chk("R8 mul locked in normal mode", A_MUL, 16'h2C0B);
        reg_wr(A_CTL, 16'h0001);
        reg_chk("R8 ctl locked in normal mode", A_CTL, 16'h0002);
        reg_wr(A_MODE, 16'h0001);
        reg_wr(A_DIV, 16'h000A);
        reg_chk("R8 div locked in light mode", A_DIV, 16'h0003);
        reg_wr(A_MODE, 16'h0000);
        reg_wr(A_MUL, 16'h1234);
        reg_chk("R8 mul open in deep mode", A_MUL, 16'h1234);
        reg_wr(A_DIV, 16'hFFFA);
        reg_chk("R8 div open in deep mode", A_DIV, 16'h000A);

        // R11 unassigned offset and out-of-window address
        reg_wr(A_HOLE, 16'hBEEF);
        reg_chk("R11 hole reads zero", A_HOLE, 16'h0000);
        reg_wr(19'h0_0010, 16'hFACE);
        reg_chk("R11 outside window reads zero", 19'h0_0010, 16'h0000);
        reg_chk("R11 no alias into scratch", A_SCR, shadow[0]);

        // R10 soft reset
        reg_wr(A_MODE, 16'h0002);
        reg_wr(A_SRST, 16'hFEFF);
        reg_chk("R10 bit8 clear no effect", A_SCR + 19'h4, shadow[2]);
        reg_chk("R10 mode kept", A_MODE, 16'h0002);
        reg_chk("R10 reads zero", A_SRST, 16'h0000);
        reg_wr(A_SRST, 16'h0100);
        reg_chk("R10 mode default", A_MODE, 16'h0000);
        reg_chk("R10 mul default", A_MUL, 16'h2C0B);
        reg_chk("R10 div default", A_DIV, 16'h0003);
        reg_chk("R10 ctl default", A_CTL, 16'h0000);
        for (int i = 0; i < NSCR; i++)
            reg_chk("R10 scratch default", A_SCR + 19'(2 * i), 16'h0000);

        check("R7 doe idle at end", 16'(bus_doe), 16'h0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule